// File: doc/BRIEF.md
# Serial Receiver Status Flags

This block keeps the status flags of an asynchronous serial port and produces its interrupt request. It sits between the receive shift logic and the bus. It takes in four kinds of input: a pulse for each completed received word, with that word's noise mark; a per-bit-time sample of the receive line; a level that is high while the transmitter is sending; and single-cycle bus strobes for status reads and data reads. From these it keeps a holding register for the received word, flags for data-ready, overrun, noise, idle line and transmit-complete, and one registered interrupt line.

Software clears a receive flag in two steps. First it reads the status byte while the flag is set. Then it reads the data register. Each flag has a private arm bit that the status read sets. The data read clears only the armed flags, so an event that arrives between the two reads is not lost. When a word completes while the previous word is still unread, the old word is kept and the new one is dropped. An idle line is reported once. It is not reported again until another word has been received.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `status` reads 0x10 (transmit-complete set, every receive flag clear), `data_q` is zero and `irq` is low.
- R2: A `rx_word_done` pulse while data-ready (status bit 0) is clear loads `rx_word` into `data_q` and sets bit 0 on the next cycle.
- R3: Data-ready clears only when a data read follows a status read that saw it set. A data read with no such status read before it leaves the flag set.
- R4: A `rx_word_done` pulse while data-ready is still set, and is not being cleared in that same cycle, sets overrun (status bit 1). The pulse leaves `data_q` unchanged.
- R5: Noise (status bit 2) takes the `rx_noisy` value of the word that is loaded. The noise mark of a word dropped by overrun is ignored. Noise clears by the status-then-data sequence.
- R6: A flag that becomes set after the status read is not armed. It survives the following data read.
- R7: Idle (status bit 3) sets on the `bit_tick` that completes `IDLE_BITS` consecutive ones on `line_bit`. A zero sample restarts the count. The flag does not set after `IDLE_BITS`-1 ones.
- R8: Once idle has been reported, it does not set again until a word has been received, however long the line stays high.
- R9: Transmit-complete (status bit 4) is 0 on the cycle after `tx_active` is high. It is 1 after `tx_active` falls. A `tc_clr` pulse clears it.
- R10: `irq` is the OR of data-ready or overrun under `rx_ie`, idle under `idle_ie`, and transmit-complete under `tc_ie`. It is registered, so it follows a change in a flag or an enable one cycle later. With all enables low it stays low.
- R11: When a data read that clears an armed data-ready meets a new word in the same cycle, the read returns the old word. The new word then loads with no overrun, and data-ready stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word_done | input | 1 | Pulse: a received word is complete in the shift register |
| rx_word | input | DATA_W | The completed word |
| rx_noisy | input | 1 | Noise mark for the completed word |
| bit_tick | input | 1 | Pulse once per bit time |
| line_bit | input | 1 | Receive line sample for this bit time |
| tx_active | input | 1 | High while a transmission is in progress |
| tc_clr | input | 1 | Pulse: clear transmit-complete |
| stat_rd | input | 1 | Bus read strobe for the status byte |
| data_rd | input | 1 | Bus read strobe for the data register |
| rx_ie | input | 1 | Enable for the data-ready and overrun interrupts |
| idle_ie | input | 1 | Enable for the idle interrupt |
| tc_ie | input | 1 | Enable for the transmit-complete interrupt |
| status | output | 8 | {3'b0, tc, idle, noise, overrun, ready} |
| data_q | output | DATA_W | Held received word |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench uses the default parameters: DATA_W = 8 and IDLE_BITS = 10. With these it can drive the exact boundary between nine and ten high bit times, and a zero sample partway through a run, at low cost. Eight-bit data words make an overrun visible: the dropped word differs from the kept one. The bench also exercises the two same-cycle orderings, a data read meeting a new word and an event arriving between the two reads.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_W    = 8,
  parameter int IDLE_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_word_done,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rx_noisy,
  input  logic              bit_tick,
  input  logic              line_bit,
  input  logic              tx_active,
  input  logic              tc_clr,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              rx_ie,
  input  logic              idle_ie,
  input  logic              tc_ie,
  output logic [7:0]        status,
  output logic [DATA_W-1:0] data_q,
  output logic              irq
);

  localparam int CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(IDLE_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_BITS - 1);

  logic rdf, ovr, nf, idle, tc, tx_d, idle_ok;
  logic [3:0] arm;
  logic [CNT_W-1:0] ones;

  wire [3:0] rx_flags = {idle, nf, ovr, rdf};
  wire [3:0] clr      = data_rd ? arm : 4'b0;
  wire rdf_left = rdf & ~clr[0];
  wire load     = rx_word_done & ~rdf_left;
  wire lost     = rx_word_done & rdf_left;
  wire idle_hit = bit_tick & line_bit & (ones == CNT_LAST) & idle_ok;

  assign status = {3'b000, tc, idle, nf, ovr, rdf};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdf <= 1'b0; ovr <= 1'b0; nf <= 1'b0; idle <= 1'b0;
      tc <= 1'b1; tx_d <= 1'b0; idle_ok <= 1'b1;
      arm <= '0; ones <= '0; data_q <= '0; irq <= 1'b0;
    end else begin
      rdf  <= load | rdf_left;
      ovr  <= lost | (ovr & ~clr[1]);
      nf   <= load ? rx_noisy : (nf & ~clr[2]);
      idle <= idle_hit | (idle & ~clr[3]);
      if (load) data_q <= rx_word;
      if (stat_rd)      arm <= rx_flags & ~clr;
      else if (data_rd) arm <= '0;
      if (rx_word_done)  ones <= '0;
      else if (bit_tick) begin
        if (!line_bit)           ones <= '0;
        else if (ones != CNT_TOP) ones <= ones + 1'b1;
      end
      idle_ok <= rx_word_done | (idle_ok & ~idle_hit);
      tx_d <= tx_active;
      if (tx_active)   tc <= 1'b0;
      else if (tx_d)   tc <= 1'b1;
      else if (tc_clr) tc <= 1'b0;
      irq <= (rx_ie & (rdf | ovr)) | (idle_ie & idle) | (tc_ie & tc);
    end
  end

  // R2
  rdf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word_done && !rdf) |=> (rdf && data_q == $past(rx_word)));

  // R4
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word_done && rdf && !data_rd) |=> (ovr && $stable(data_q)));

  // R3
  rdf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdf && !arm[0]) |=> rdf);

  // R8
  idle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_ok && !idle) |=> !idle);

  // R9
  tc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> !tc);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ie && !idle_ie && !tc_ie) |=> !irq);

endmodule

// File: tb/sim_uart_rx_status.sv
module sim_uart_rx_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_word_done = 0, rx_noisy = 0, bit_tick = 0, line_bit = 1;
  logic tx_active = 0, tc_clr = 0, stat_rd = 0, data_rd = 0;
  logic rx_ie = 0, idle_ie = 0, tc_ie = 0;
  logic [7:0] rx_word = '0;
  logic [7:0] status, data_q;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_rx_status #(.DATA_W(8), .IDLE_BITS(10)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_word_done(rx_word_done), .rx_word(rx_word),
    .rx_noisy(rx_noisy), .bit_tick(bit_tick), .line_bit(line_bit),
    .tx_active(tx_active), .tc_clr(tc_clr), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_ie(rx_ie), .idle_ie(idle_ie), .tc_ie(tc_ie),
    .status(status), .data_q(data_q), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [7:0] w, input logic noisy);
    rx_word = w; rx_noisy = noisy; rx_word_done = 1;
    @(negedge clk);
    rx_word_done = 0; rx_noisy = 0;
  endtask

  task automatic sread();
    stat_rd = 1; @(negedge clk); stat_rd = 0;
  endtask

  task automatic dread();
    data_rd = 1; @(negedge clk); data_rd = 0;
  endtask

  task automatic clear_seq();
    sread(); dread();
  endtask

  task automatic bits(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; line_bit = v; @(negedge clk);
      bit_tick = 0; line_bit = 1; @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h10);
    chk("R1 data", data_q, 8'h00);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_load_clear();
    push_word(8'hA5, 0);
    chk("R2 status", status, 8'h11);
    chk("R2 data", data_q, 8'hA5);
    dread();
    chk("R3 unarmed read keeps flag", status, 8'h11);
    clear_seq();
    chk("R3 sequence clears", status, 8'h10);
  endtask

  task automatic t_overrun();
    push_word(8'h3C, 0);
    push_word(8'hC3, 1);
    chk("R4 overrun flag", status, 8'h13);
    chk("R4 data kept", data_q, 8'h3C);
    clear_seq();
    chk("R4 overrun cleared", status, 8'h10);
  endtask

  task automatic t_noise();
    push_word(8'h5A, 1);
    chk("R5 noise set", status, 8'h15);
    clear_seq();
    chk("R5 noise cleared", status, 8'h10);
  endtask

  task automatic t_arm();
    push_word(8'h01, 0);
    sread();
    push_word(8'h02, 0);
    chk("R6 late overrun", status, 8'h13);
    dread();
    chk("R6 unarmed flag survives", status, 8'h12);
    chk("R6 data", data_q, 8'h01);
    clear_seq();
    chk("R6 final clear", status, 8'h10);
  endtask

  task automatic t_same_cycle();
    push_word(8'h11, 0);
    sread();
    chk("R11 read returns old word", data_q, 8'h11);
    data_rd = 1; rx_word = 8'h22; rx_word_done = 1;
    @(negedge clk);
    data_rd = 0; rx_word_done = 0;
    chk("R11 no overrun", status, 8'h11);
    chk("R11 new word loaded", data_q, 8'h22);
    clear_seq();
    chk("R11 cleared", status, 8'h10);
  endtask

  task automatic t_idle();
    bits(1, 0); bits(5, 1); bits(1, 0); bits(9, 1);
    chk("R7 nine ones not idle", status, 8'h10);
    bits(1, 1);
    chk("R7 tenth one sets idle", status, 8'h18);
    clear_seq();
    chk("R7 idle cleared", status, 8'h10);
    bits(15, 1);
    chk("R8 no re-assert on idle line", status, 8'h10);
    push_word(8'h77, 0);
    clear_seq();
    bits(10, 1);
    chk("R8 idle after new word", status, 8'h18);
    clear_seq();
    chk("R8 cleared", status, 8'h10);
  endtask

  task automatic t_tc();
    tx_active = 1; @(negedge clk);
    chk("R9 busy clears tc", status, 8'h00);
    @(negedge clk);
    tx_active = 0; @(negedge clk);
    chk("R9 done sets tc", status, 8'h10);
    tc_clr = 1; @(negedge clk); tc_clr = 0;
    chk("R9 tc_clr", status, 8'h00);
    tx_active = 1; @(negedge clk); tx_active = 0; @(negedge clk);
    chk("R9 tc back", status, 8'h10);
  endtask

  task automatic t_irq();
    rx_ie = 1;
    push_word(8'h99, 0);
    chk("R10 irq lags flag", irq, 0);
    @(negedge clk);
    chk("R10 rx irq", irq, 1);
    clear_seq();
    @(negedge clk);
    chk("R10 rx irq drops", irq, 0);
    rx_ie = 0; tc_ie = 1; @(negedge clk);
    chk("R10 tc irq", irq, 1);
    tc_ie = 0; @(negedge clk);
    chk("R10 tc irq masked", irq, 0);
    idle_ie = 1;
    push_word(8'h44, 0);
    clear_seq();
    bits(10, 1);
    chk("R10 idle irq", irq, 1);
    idle_ie = 0; @(negedge clk);
    chk("R10 idle irq masked", irq, 0);
    clear_seq();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load_clear();
    t_overrun();
    t_noise();
    t_arm();
    t_same_cycle();
    t_idle();
    t_tc();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule